// File: doc/BRIEF.md
# Supply-Fail Write-Protect Sequencer

This block is the clocked control core of a battery-backed memory supervisor. It reads two comparator flags. One says the supply is above the write-protect trip level. The other says the supply is above the lower level where the memory switches to the backup source. From these flags it drives four outputs: a write-protect signal that also isolates the memory bus, a backup-source select, a flag showing that backup is armed, and a sticky data-lost flag. It also gates the host chip-select, write and read strobes. While protection is active, nothing from the host reaches the memory and the data drivers stay off.

A new part leaves reset sealed. In this state the backup source stays disconnected until the supply first reaches a valid level. Once armed, backup stays armed until the next reset. If the supply collapses below the switch-over level while the part is still sealed, the contents cannot have been retained, so the data-lost flag is set. It stays set until software clears it.

Protection is released only after the trip flag has been stable high for a debounce window and a long hold has then run out. If the flag drops during the hold, protection stays on and the next recovery starts the hold over. Both comparator flags pass through synchronisers. The debounce acts only on the rising edge of the trip flag, so protection on a falling supply is not delayed.

Top module: `pwr_guard_seq`

## Requirements
- R1: While reset is held and just after it is released, wrProtect is 1 and useBackup, backupArmed, dataLost, memSel, memWr and dataOe are all 0.
- R2: When tripOkRaw falls while the block is in normal operation, wrProtect is 1 at the SYNC_STAGES-th rising edge that samples the low flag (edge 2 with defaults).
- R3: While wrProtect is 1, memSel, memWr and dataOe are 0 whatever the host inputs are. While wrProtect is 0, memSel = hostSel, memWr = hostSel AND hostWr, and dataOe = hostSel AND hostRd AND NOT hostWr.
- R4: Once armed and protected, useBackup goes to 1 when swOkRaw drops, and back to 0 when swOkRaw returns high. wrProtect stays 1 throughout.
- R5: backupArmed goes to 1 on the first qualified rise of the trip flag after reset and then stays 1 until reset.
- R6: After tripOkRaw rises (swOkRaw high), wrProtect falls at rising edge SYNC_STAGES + DEBOUNCE_CYC + 1 + HOLD_CYC. Edges are counted from the first edge that samples the raised flag, which gives 47 with the bench values 2, 4 and 40.
- R7: If tripOkRaw drops during the hold, wrProtect stays 1, and the next recovery again takes the full R6 latency.
- R8: A high pulse on tripOkRaw shorter than DEBOUNCE_CYC cycles does not release protection and does not arm backup.
- R9: dataLost is set when the synchronised swOkRaw falls while the block is still sealed. It stays set until a cycle with clrLost high, and it is never set once backup is armed.
- R10: useBackup is never 1 while backup is not yet armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset; returns the block to the sealed state |
| tripOkRaw | input | 1 | Comparator: supply above write-protect trip level (asynchronous) |
| swOkRaw | input | 1 | Comparator: supply above backup switch-over level (asynchronous) |
| clrLost | input | 1 | Clears the data-lost flag |
| hostSel | input | 1 | Host memory select, active high |
| hostWr | input | 1 | Host write strobe, active high |
| hostRd | input | 1 | Host read strobe, active high |
| wrProtect | output | 1 | Write protect and bus isolate |
| useBackup | output | 1 | Selects the backup source for the memory supply |
| backupArmed | output | 1 | Backup has been connected since the first valid power-up |
| dataLost | output | 1 | Sticky: supply collapsed while backup was still sealed |
| memSel | output | 1 | Gated memory select |
| memWr | output | 1 | Gated memory write strobe |
| dataOe | output | 1 | Gated memory data output enable |

## Verification
The bench measures the exact release latency after each recovery. A hold counter that does not restart on a drop, or that is off by one, shows up as a wrong cycle count. It sends trip-flag glitches shorter than the debounce window. A debounce applied on the wrong edge, or a counter that is not cleared, would either release protection too early or slow down the fall response. It collapses the supply below the switch-over level both while sealed and after arming. A design that mixes these up would select an unconnected battery or lose the data-lost indication. Random host strobes during protected phases catch any gating leak onto the memory bus.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

  typedef enum logic [2:0] {
    ST_SEALED  = 3'd0,
    ST_NORMAL  = 3'd1,
    ST_PROTECT = 3'd2,
    ST_BACKUP  = 3'd3,
    ST_HOLD    = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic holdRun;
    logic armSet;
    logic sealed;
    logic protect;
    logic backupSel;
  } ctlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic tripQual;
    logic swOk;
    logic swFell;
    logic holdDone;
  } dpStatus_t;

endpackage

// File: rtl/pwr_guard_sync.sv
module pwr_guard_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/pwr_guard_dp.sv
module pwr_guard_dp
  import pwr_guard_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int DEBOUNCE_CYC = 4,
  parameter int HOLD_CYC     = 15_625_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tripOkRaw,
  input  logic       swOkRaw,
  input  logic       clrLost,
  input  logic       hostSel,
  input  logic       hostWr,
  input  logic       hostRd,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status,
  output logic       wrProtect,
  output logic       useBackup,
  output logic       backupArmed,
  output logic       dataLost,
  output logic       memSel,
  output logic       memWr,
  output logic       dataOe
);

  localparam int DB_W   = (DEBOUNCE_CYC > 0) ? $clog2(DEBOUNCE_CYC + 1) : 1;
  localparam int HOLD_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);

  logic [1:0] syncOut;
  logic       tripSync;
  logic       swSync;
  logic       swPrev;
  logic       tripQual;
  logic       holdDone;
  logic [HOLD_W-1:0] holdCnt;
  logic       armedQ;
  logic       lostQ;

  pwr_guard_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({tripOkRaw, swOkRaw}),
    .dout (syncOut)
  );

  assign tripSync = syncOut[1];
  assign swSync   = syncOut[0];

  // Debounce only the rising edge of the trip flag; a low flag disqualifies at once
  if (DEBOUNCE_CYC == 0) begin : g_nodb
    assign tripQual = tripSync;
  end else begin : g_db
    logic [DB_W-1:0] dbCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              dbCnt <= '0;
      else if (!tripSync)                     dbCnt <= '0;
      else if (dbCnt != DB_W'(DEBOUNCE_CYC))  dbCnt <= dbCnt + 1'b1;
    end
    assign tripQual = tripSync && (dbCnt == DB_W'(DEBOUNCE_CYC));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) swPrev <= 1'b0;
    else       swPrev <= swSync;
  end

  // Post-recovery hold counter, cleared whenever the hold is not running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdCnt <= '0;
    else if (!strobe.holdRun) holdCnt <= '0;
    else if (!holdDone)       holdCnt <= holdCnt + 1'b1;
  end

  assign holdDone = (holdCnt == HOLD_LAST);

  // One-time seal break
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              armedQ <= 1'b0;
    else if (strobe.armSet) armedQ <= 1'b1;
  end

  // Sticky loss flag: set beats clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           lostQ <= 1'b0;
    else if (strobe.sealed && swPrev && !swSync) lostQ <= 1'b1;
    else if (clrLost)                    lostQ <= 1'b0;
  end

  always_comb begin
    status          = '0;
    status.tripQual = tripQual;
    status.swOk     = swSync;
    status.swFell   = swPrev & ~swSync;
    status.holdDone = holdDone;
  end

  // Protection is combinational on the qualified flag so a fall is not delayed by the FSM
  assign wrProtect   = strobe.protect | ~tripQual;
  assign useBackup   = strobe.backupSel & armedQ;
  assign backupArmed = armedQ;
  assign dataLost    = lostQ;

  // Bus isolation
  assign memSel = hostSel & ~wrProtect;
  assign memWr  = hostSel & hostWr & ~wrProtect;
  assign dataOe = hostSel & hostRd & ~hostWr & ~wrProtect;

endmodule

// File: rtl/pwr_guard_ctl.sv
module pwr_guard_ctl
  import pwr_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe
);

  seqState_t state;
  seqState_t nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SEALED;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_SEALED:  if (status.tripQual) nextState = ST_HOLD;
      ST_NORMAL:  if (!status.tripQual) nextState = ST_PROTECT;
      ST_PROTECT: begin
        if (!status.swOk)         nextState = ST_BACKUP;
        else if (status.tripQual) nextState = ST_HOLD;
      end
      ST_BACKUP:  if (status.swOk) nextState = ST_PROTECT;
      ST_HOLD: begin
        if (!status.tripQual)     nextState = ST_PROTECT;
        else if (status.holdDone) nextState = ST_NORMAL;
      end
      default:    nextState = ST_SEALED;
    endcase
  end

  always_comb begin
    strobe           = '0;
    strobe.holdRun   = (state == ST_HOLD);
    strobe.armSet    = (state == ST_SEALED) && status.tripQual;
    strobe.sealed    = (state == ST_SEALED);
    strobe.protect   = (state != ST_NORMAL);
    strobe.backupSel = (state == ST_BACKUP);
  end

endmodule

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq
  import pwr_guard_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int DEBOUNCE_CYC = 4,
  parameter int HOLD_CYC     = 15_625_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic tripOkRaw,
  input  logic swOkRaw,
  input  logic clrLost,
  input  logic hostSel,
  input  logic hostWr,
  input  logic hostRd,
  output logic wrProtect,
  output logic useBackup,
  output logic backupArmed,
  output logic dataLost,
  output logic memSel,
  output logic memWr,
  output logic dataOe
);

  ctlStrobe_t strobe;
  dpStatus_t  status;

  pwr_guard_dp #(
    .SYNC_STAGES  (SYNC_STAGES),
    .DEBOUNCE_CYC (DEBOUNCE_CYC),
    .HOLD_CYC     (HOLD_CYC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .tripOkRaw   (tripOkRaw),
    .swOkRaw     (swOkRaw),
    .clrLost     (clrLost),
    .hostSel     (hostSel),
    .hostWr      (hostWr),
    .hostRd      (hostRd),
    .strobe      (strobe),
    .status      (status),
    .wrProtect   (wrProtect),
    .useBackup   (useBackup),
    .backupArmed (backupArmed),
    .dataLost    (dataLost),
    .memSel      (memSel),
    .memWr       (memWr),
    .dataOe      (dataOe)
  );

  pwr_guard_ctl u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .status (status),
    .strobe (strobe)
  );

endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk (
  input logic clk,
  input logic rstN,
  input logic tripOkRaw,
  input logic clrLost,
  input logic wrProtect,
  input logic useBackup,
  input logic backupArmed,
  input logic dataLost,
  input logic memSel,
  input logic memWr,
  input logic dataOe
);

  // R2: two cycles of a low raw trip flag guarantee protection (default two-stage synchroniser)
  a_r2_fall_protect: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(tripOkRaw, 1) && !$past(tripOkRaw, 2)) |-> wrProtect);

  a_r3_bus_isolated: assert property (@(posedge clk) disable iff (!rstN)
    wrProtect |-> (!memSel && !memWr && !dataOe));

  a_r4_backup_protected: assert property (@(posedge clk) disable iff (!rstN)
    useBackup |-> wrProtect);

  a_r5_armed_sticky: assert property (@(posedge clk) disable iff (!rstN)
    backupArmed |=> backupArmed);

  a_r9_lost_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (dataLost && !clrLost) |=> dataLost);

  a_r10_sealed_no_backup: assert property (@(posedge clk) disable iff (!rstN)
    !backupArmed |-> !useBackup);

endmodule

bind pwr_guard_seq pwr_guard_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .tripOkRaw   (tripOkRaw),
  .clrLost     (clrLost),
  .wrProtect   (wrProtect),
  .useBackup   (useBackup),
  .backupArmed (backupArmed),
  .dataLost    (dataLost),
  .memSel      (memSel),
  .memWr       (memWr),
  .dataOe      (dataOe)
);

// File: tb/pwr_guard_seq_tb.sv
`timescale 1ns/1ps
module pwr_guard_seq_tb;

  localparam int SYNC = 2;
  localparam int DEB  = 4;
  localparam int HOLD = 40;
  localparam int SLEW = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tripOkRaw = 1'b0;
  logic swOkRaw = 1'b1;
  logic clrLost = 1'b0;
  logic hostSel = 1'b0;
  logic hostWr = 1'b0;
  logic hostRd = 1'b0;
  logic wrProtect, useBackup, backupArmed, dataLost, memSel, memWr, dataOe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_guard_seq #(
    .SYNC_STAGES  (SYNC),
    .DEBOUNCE_CYC (DEB),
    .HOLD_CYC     (HOLD)
  ) u_dut (
    .clk (clk), .rstN (rstN), .tripOkRaw (tripOkRaw), .swOkRaw (swOkRaw),
    .clrLost (clrLost), .hostSel (hostSel), .hostWr (hostWr), .hostRd (hostRd),
    .wrProtect (wrProtect), .useBackup (useBackup), .backupArmed (backupArmed),
    .dataLost (dataLost), .memSel (memSel), .memWr (memWr), .dataOe (dataOe)
  );

  function automatic int expRelease();
    return SYNC + DEB + 1 + HOLD;
  endfunction

  function automatic logic [2:0] expGate(input logic s, input logic w, input logic r, input logic p);
    if (p) return 3'b000;
    return {s, s & w, s & r & ~w};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // rising edges from the trip rise until protection is released
  task automatic measureRelease(output int n);
    tripOkRaw = 1'b1;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (wrProtect && n < 500);
  endtask

  task automatic measureFall(output int n);
    tripOkRaw = 1'b0;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!wrProtect && n < 500);
  endtask

  task automatic randGate(input string req, input int n, input logic prot);
    for (int i = 0; i < n; i++) begin
      {hostSel, hostWr, hostRd} = 3'($urandom);
      #1;
      check(req, "gated strobes", int'({memSel, memWr, dataOe}),
            int'(expGate(hostSel, hostWr, hostRd, prot)));
      @(negedge clk);
    end
    {hostSel, hostWr, hostRd} = 3'b000;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    int gap;
    void'($urandom(32'd7321));

    // R1: reset state, host strobes active
    {hostSel, hostWr, hostRd} = 3'b111;
    waitNeg(4);
    check("R1", "wrProtect in reset", wrProtect, 1);
    check("R1", "memSel in reset", memSel, 0);
    rstN = 1'b1;
    waitNeg(1);
    check("R1", "outputs after reset", int'({wrProtect, useBackup, backupArmed, dataLost}), 8);
    check("R1", "memWr after reset", memWr, 0);
    waitNeg(8);

    // R3 while sealed
    randGate("R3", 8, 1'b1);

    // R9, R10: supply collapse while sealed
    swOkRaw = 1'b0;
    waitNeg(SLEW);
    check("R9", "dataLost set while sealed", dataLost, 1);
    check("R10", "no backup while sealed", useBackup, 0);
    swOkRaw = 1'b1;
    waitNeg(SLEW);
    check("R9", "dataLost sticky", dataLost, 1);
    clrLost = 1'b1;
    waitNeg(1);
    clrLost = 1'b0;
    waitNeg(1);
    check("R9", "dataLost cleared", dataLost, 0);

    // R5, R6: first valid power-up
    measureRelease(n);
    check("R6", "first release latency", n, expRelease());
    check("R5", "armed after first power-up", backupArmed, 1);

    // R3 in normal operation
    randGate("R3", 24, 1'b0);

    // R2: fall latency
    measureFall(n);
    check("R2", "protect latency on fall", n, SYNC);
    waitNeg(SLEW);

    // R8: short glitch does not release
    tripOkRaw = 1'b1;
    waitNeg(DEB - 1);
    tripOkRaw = 1'b0;
    waitNeg(60);
    check("R8", "protect after glitch", wrProtect, 1);
    randGate("R3", 6, 1'b1);

    // R7: drop during hold
    tripOkRaw = 1'b1;
    waitNeg(20);
    check("R7", "protect during hold", wrProtect, 1);
    tripOkRaw = 1'b0;
    waitNeg(SLEW);
    check("R7", "protect after drop in hold", wrProtect, 1);
    measureRelease(n);
    check("R7", "full hold after drop", n, expRelease());

    // R4, R9: deep outage once armed
    tripOkRaw = 1'b0;
    waitNeg(SLEW);
    swOkRaw = 1'b0;
    waitNeg(6);
    check("R4", "backup selected", useBackup, 1);
    check("R4", "protected in backup", wrProtect, 1);
    check("R9", "no loss when armed", dataLost, 0);
    swOkRaw = 1'b1;
    waitNeg(6);
    check("R4", "backup released", useBackup, 0);
    check("R4", "still protected", wrProtect, 1);
    waitNeg(SLEW);
    measureRelease(n);
    check("R6", "release after outage", n, expRelease());

    // Constrained random supply profiles
    for (int it = 0; it < 30; it++) begin
      int act;
      act = int'($urandom_range(2, 0));
      gap = int'($urandom_range(SLEW + 40, SLEW));
      tripOkRaw = 1'b0;
      waitNeg(gap);
      if (act == 1) begin
        swOkRaw = 1'b0;
        waitNeg(gap);
        check("R4", "random backup", useBackup, 1);
        randGate("R3", 4, 1'b1);
        swOkRaw = 1'b1;
        waitNeg(gap);
        check("R4", "random backup off", useBackup, 0);
      end else if (act == 2) begin
        tripOkRaw = 1'b1;
        waitNeg(int'($urandom_range(40, 10)));
        check("R7", "random hold protect", wrProtect, 1);
        tripOkRaw = 1'b0;
        waitNeg(gap);
      end else begin
        randGate("R3", 4, 1'b1);
      end
      measureRelease(n);
      check("R6", "random release latency", n, expRelease());
      check("R5", "armed stays", backupArmed, 1);
      check("R9", "no loss in random", dataLost, 0);
      randGate("R3", 3, 1'b0);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule